// File: doc/BRIEF.md
# Latched Status Event Register

This block keeps a set of sticky event flags for a status reporting tree. Each cycle it compares a condition vector with the value it held one cycle earlier. Any bit that has just risen from 0 to 1 sets its matching event flag. A flag stays set until the host does a destructive read of the event word or issues a global clear. A condition that stays high, or that falls, does not set a flag.

A host-writable enable mask is ANDed with the latched flags. The OR of the result is a summary bit, which feeds one bit of a status byte. When the summary goes from 0 to 1, a single-cycle service-request pulse fires. The mask resets to zero, so no requests are raised after reset until software enables some bits.

The width is set by the parameter `WIDTH`, which supports 8 or 16 bits. Command parsing, number formatting and message transport sit outside this block.

Top module: `status_event_reg`

## Requirements
- R1: An event bit sets only when its condition bit was 0 in the previous clock cycle and is 1 now. A condition held high or a falling condition never sets it.
- R2: A set event bit stays set until a read strobe or a global clear.
- R3: While `rd_evt_i` is high, `evt_rdata_o` shows the current event bits. After that clock edge, all bits that had no new rising edge read 0.
- R4: A rising condition edge in the same cycle as a read strobe or a global clear leaves its event bit set after the edge.
- R5: `clr_all_i` zeroes the event bits and leaves the enable mask unchanged.
- R6: `summary_o` is 1 exactly when some event bit and its enable bit are both 1. It follows the registered event and mask values in the same cycle.
- R7: A write (`en_wr_i`) loads `en_wdata_i` into the enable mask, which reads back on `en_rdata_o` from the next cycle. The mask resets to all zeros.
- R8: `srq_o` is high for exactly one cycle, in the first cycle that `summary_o` is 1 after being 0. It is never high while `summary_o` is 0.
- R9: The first clock edge after reset is not treated as an edge. A condition already high when reset is released sets no event bit.
- R10: During reset and in the first cycle after it, the event bits, the enable mask, `summary_o` and `srq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_i | input | WIDTH | Condition vector being watched |
| rd_evt_i | input | 1 | Destructive read strobe for the event word |
| clr_all_i | input | 1 | Global clear of the event bits |
| en_wr_i | input | 1 | Enable mask write strobe |
| en_wdata_i | input | WIDTH | Enable mask write data |
| evt_rdata_o | output | WIDTH | Latched event bits |
| en_rdata_o | output | WIDTH | Enable mask readback |
| summary_o | output | 1 | OR of the enabled event bits |
| srq_o | output | 1 | One-cycle service-request pulse |

## Verification
The hardest case to reach is a fresh rising condition edge that lands in the same cycle as a read strobe or a clear. From the ports it only appears when a condition toggle and a host access happen to line up. The stimulus therefore sets this up on purpose: one flag is already latched while a different condition bit rises in the very cycle of the read, and again in the cycle of the clear. A long random phase then makes such collisions, and toggling of the enable mask while flags are pending, happen often. Throughout, a behavioural model compares every output on every cycle.

// File: rtl/stev_pkg.sv
package stev_pkg;
  localparam int MAX_W = 16;
  typedef logic [MAX_W-1:0] stev_vec_t;

  // bits that went from 0 to 1 since the previous sample, gated by arm
  function automatic stev_vec_t rise_bits(stev_vec_t cur, stev_vec_t prev, logic armed);
    return armed ? (cur & ~prev) : '0;
  endfunction

  // next event word: wipe drops old bits, fresh rises always survive
  function automatic stev_vec_t next_events(stev_vec_t evt, stev_vec_t rise, logic wipe);
    return (wipe ? '0 : evt) | rise;
  endfunction

  // OR reduction of enabled events
  function automatic logic masked_any(stev_vec_t evt, stev_vec_t en);
    return |(evt & en);
  endfunction
endpackage

// File: rtl/stev_edge.sv
module stev_edge
  import stev_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cond_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] cond_q;
  logic             armed_q;
  stev_vec_t        rise_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      cond_q  <= cond_i;
      armed_q <= 1'b1;
    end
  end

  always_comb rise_full = rise_bits(stev_vec_t'(cond_i), stev_vec_t'(cond_q), armed_q);
  assign rise_o = rise_full[WIDTH-1:0];
endmodule

// File: rtl/stev_latch.sv
module stev_latch
  import stev_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rise_i,
  input  logic             wipe_i,
  output logic [WIDTH-1:0] evt_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_cell
    logic cell_q;
    stev_vec_t cell_next;
    always_comb cell_next = next_events(stev_vec_t'(cell_q), stev_vec_t'(rise_i[b]), wipe_i);
    always_ff @(posedge clk) begin
      if (!rst_n) cell_q <= 1'b0;
      else        cell_q <= cell_next[0];
    end
    assign evt_o[b] = cell_q;
  end
endmodule

// File: rtl/stev_mask.sv
module stev_mask
  import stev_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] evt_i,
  output logic [WIDTH-1:0] en_o,
  output logic             summary_o
);
  logic [WIDTH-1:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    en_q <= '0;
    else if (wr_i) en_q <= wdata_i;
  end

  assign en_o      = en_q;
  assign summary_o = masked_any(stev_vec_t'(evt_i), stev_vec_t'(en_q));
endmodule

// File: rtl/stev_srq.sv
module stev_srq (
  input  logic clk,
  input  logic rst_n,
  input  logic summary_i,
  output logic srq_o
);
  logic sum_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sum_q <= 1'b0;
    else        sum_q <= summary_i;
  end

  assign srq_o = summary_i & ~sum_q;
endmodule

// File: rtl/status_event_reg.sv
module status_event_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cond_i,
  input  logic             rd_evt_i,
  input  logic             clr_all_i,
  input  logic             en_wr_i,
  input  logic [WIDTH-1:0] en_wdata_i,
  output logic [WIDTH-1:0] evt_rdata_o,
  output logic [WIDTH-1:0] en_rdata_o,
  output logic             summary_o,
  output logic             srq_o
);
  // named internal events, visible to the bound checker
  logic [WIDTH-1:0] cond_rise;
  logic             evt_wipe;
  logic [WIDTH-1:0] evt_bits;
  logic [WIDTH-1:0] en_bits;
  logic             sum_lvl;

  assign evt_wipe = rd_evt_i | clr_all_i;

  stev_edge #(.WIDTH(WIDTH)) u_edge (
    .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .rise_o(cond_rise)
  );

  stev_latch #(.WIDTH(WIDTH)) u_latch (
    .clk(clk), .rst_n(rst_n), .rise_i(cond_rise), .wipe_i(evt_wipe), .evt_o(evt_bits)
  );

  stev_mask #(.WIDTH(WIDTH)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_i(en_wr_i), .wdata_i(en_wdata_i),
    .evt_i(evt_bits), .en_o(en_bits), .summary_o(sum_lvl)
  );

  stev_srq u_srq (
    .clk(clk), .rst_n(rst_n), .summary_i(sum_lvl), .srq_o(srq_o)
  );

  assign evt_rdata_o = evt_bits;
  assign en_rdata_o  = en_bits;
  assign summary_o   = sum_lvl;
endmodule

// File: rtl/status_event_reg_chk.sv
module status_event_reg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] cond_i,
  input logic             rd_evt_i,
  input logic             clr_all_i,
  input logic             en_wr_i,
  input logic [WIDTH-1:0] en_wdata_i,
  input logic [WIDTH-1:0] evt_rdata_o,
  input logic [WIDTH-1:0] en_rdata_o,
  input logic             summary_o,
  input logic             srq_o
);
  logic past_ok;
  logic armed_seen;
  logic [WIDTH-1:0] cond_prev;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      past_ok    <= 1'b0;
      armed_seen <= 1'b0;
      cond_prev  <= '0;
    end else begin
      past_ok    <= 1'b1;
      armed_seen <= past_ok;
      cond_prev  <= cond_i;
    end
  end

  // R1
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |=> ((evt_rdata_o & ~$past(evt_rdata_o)) & ~($past(cond_i) & ~$past(cond_prev))) == '0);

  // R2
  event_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_evt_i && !clr_all_i) |=> ((evt_rdata_o & $past(evt_rdata_o)) == $past(evt_rdata_o)));

  // R3
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt_i |=> ((evt_rdata_o & ~($past(cond_i) & ~$past(cond_prev))) == '0));

  // R4
  edge_beats_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_seen && (rd_evt_i || clr_all_i)) |=>
      ((evt_rdata_o & ($past(cond_i) & ~$past(cond_prev))) == ($past(cond_i) & ~$past(cond_prev))));

  // R5
  clear_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all_i && !en_wr_i) |=> $stable(en_rdata_o));

  // R7
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr_i |=> (en_rdata_o == $past(en_wdata_i)));

  // R6
  zero_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rdata_o == '0) |-> !summary_o);

  // R8
  srq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srq_o |=> !srq_o);

  // R8
  srq_needs_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srq_o |-> summary_o);
endmodule

bind status_event_reg status_event_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .rd_evt_i(rd_evt_i),
  .clr_all_i(clr_all_i), .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
  .evt_rdata_o(evt_rdata_o), .en_rdata_o(en_rdata_o),
  .summary_o(summary_o), .srq_o(srq_o)
);

// File: tb/tb_status_event_reg.sv
`timescale 1ns/1ps
module tb_status_event_reg;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] cond_i = '0;
  logic rd_evt_i = 1'b0, clr_all_i = 1'b0, en_wr_i = 1'b0;
  logic [W-1:0] en_wdata_i = '0;
  logic [W-1:0] evt_rdata_o, en_rdata_o;
  logic summary_o, srq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_evt, m_en, m_prev, m_armed, m_sum_prev;

  always #2 clk = ~clk;

  status_event_reg #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .rd_evt_i(rd_evt_i),
    .clr_all_i(clr_all_i), .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
    .evt_rdata_o(evt_rdata_o), .en_rdata_o(en_rdata_o),
    .summary_o(summary_o), .srq_o(srq_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int model_sum();
    int s = 0;
    for (int i = 0; i < W; i++)
      if (((m_evt >> i) & 1) && ((m_en >> i) & 1)) s = 1;
    return s;
  endfunction

  task automatic compare();
    int s = model_sum();
    check("R1 R2 R3 events", int'(evt_rdata_o), m_evt);
    check("R7 mask", int'(en_rdata_o), m_en);
    check("R6 summary", int'(summary_o), s);
    check("R8 srq", int'(srq_o), (s == 1 && m_sum_prev == 0) ? 1 : 0);
  endtask

  task automatic update();
    int c = int'(cond_i);
    int rise = 0;
    if (!rst_n) begin
      m_evt = 0; m_en = 0; m_prev = 0; m_armed = 0; m_sum_prev = 0;
      return;
    end
    if (m_armed != 0)
      for (int i = 0; i < W; i++)
        if (((c >> i) & 1) == 1 && ((m_prev >> i) & 1) == 0) rise += (1 << i);
    m_sum_prev = model_sum();
    if (rd_evt_i || clr_all_i) m_evt = 0;
    m_evt = m_evt | rise;
    if (en_wr_i) m_en = int'(en_wdata_i);
    m_prev = c;
    m_armed = 1;
  endtask

  // one cycle: drive at falling edge, compare outputs, advance the model
  task automatic cyc(logic [W-1:0] c, bit rd = 0, bit clr = 0, bit wr = 0, logic [W-1:0] wd = '0);
    @(negedge clk);
    cond_i = c; rd_evt_i = rd; clr_all_i = clr; en_wr_i = wr; en_wdata_i = wd;
    #0.5;
    compare();
    update();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_evt = 0; m_en = 0; m_prev = 0; m_armed = 0; m_sum_prev = 0;
    // reset with conditions high
    repeat (3) cyc('1);
    check("R10 reset events", int'(evt_rdata_o), 0);
    check("R10 reset srq", int'(srq_o), 0);
    rst_n = 1'b1;
    cyc('1);
    check("R10 first cycle mask", int'(en_rdata_o), 0);
    repeat (3) cyc('1);
    check("R9 high at release sets nothing", int'(evt_rdata_o), 0);

    // falling and steady high set nothing; rise sets
    cyc('0); cyc('0);
    check("R1 falling edge ignored", int'(evt_rdata_o), 0);
    cyc(8'h01); cyc(8'h01);
    check("R1 rise sets bit0", int'(evt_rdata_o), 8'h01);
    repeat (3) cyc(8'h01);
    check("R2 held", int'(evt_rdata_o), 8'h01);
    cyc(8'h01, 1);
    cyc(8'h01);
    check("R3 read clears", int'(evt_rdata_o), 0);
    repeat (2) cyc(8'h01);
    check("R1 steady high no reset", int'(evt_rdata_o), 0);

    // enable and service request
    cyc(8'h00, 0, 0, 1, 8'h04);
    cyc(8'h00);
    check("R7 mask readback", int'(en_rdata_o), 8'h04);
    cyc(8'h04);
    cyc(8'h04);
    check("R6 summary up", int'(summary_o), 1);
    check("R8 srq pulse", int'(srq_o), 1);
    cyc(8'h04);
    check("R8 srq one cycle", int'(srq_o), 0);

    // edge collides with read
    cyc(8'h14, 1);
    cyc(8'h14);
    check("R4 edge survives read", int'(evt_rdata_o), 8'h10);
    // edge collides with clear; mask kept
    cyc(8'h00); cyc(8'h00);
    cyc(8'h02, 0, 1);
    cyc(8'h02);
    check("R4 edge survives clear", int'(evt_rdata_o), 8'h02);
    check("R5 clear keeps mask", int'(en_rdata_o), 8'h04);
    cyc(8'h02, 0, 1);
    cyc(8'h02);
    check("R5 clear zeroes", int'(evt_rdata_o), 0);
    // disabled event cannot request
    cyc(8'h00, 0, 0, 1, 8'h00);
    cyc(8'h40); cyc(8'h40);
    check("R6 masked event quiet", int'(summary_o), 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [W-1:0] c = W'($urandom);
      bit rd  = ($urandom % 8) == 0;
      bit clr = ($urandom % 32) == 0;
      bit wr  = ($urandom % 16) == 0;
      cyc(c, rd, clr, wr, W'($urandom));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule